// File: doc/BRIEF.md
# Selectable-Wrap 16-bit Timer

This block is an up-counting 16-bit timer whose wrap point is picked by a three-bit mode input. The wrap point can be the full range, one of three fixed narrow ranges (8, 9 or 10 bits), the active value of compare channel A, or the capture register. The count restarts at zero after the cycle in which it equals the wrap point, and a one-cycle wrap pulse follows. Three compare channels raise sticky match flags and, in the waveform modes, drive fast-PWM pins.

A capture register stores the running count on a chosen edge of an already synchronous event input, and raises a capture flag. In every waveform mode, writes to compare channel A go to a shadow register. The shadow value is moved into the active register only at the wrap, so the wrap point or the duty cycle can be changed while the counter runs without glitches. In the three non-waveform modes, a write takes effect at once. The surrounding logic writes the count, the compare registers and the capture register through one shared data bus, using one strobe per register.

Top module: `wrap_timer`

## Requirements
- R1: While rst_n is low, count, cap_val, all compare registers, match_flag, cap_flag, top_pulse and pwm_out are all zero.
- R2: wr_cnt loads wr_data into the count and takes priority over counting. Otherwise the count steps by one per cycle while cnt_en is high, and holds while cnt_en is low.
- R3: The wrap point by mode value: 0 gives 0xFFFF, 1 gives 0x00FF, 2 gives 0x01FF, 3 gives 0x03FF, 4 and 6 give the active compare A value, and 5 and 7 give cap_val. Modes 1, 2, 3, 6 and 7 are waveform modes.
- R4: When cnt_en is high and the count equals the wrap point, the next count is 0. top_pulse is high for exactly the one cycle after that edge.
- R5: A match flag (bit 0 is A, bit 1 is B, bit 2 is C) sets at the edge after a cycle with cnt_en high and the count equal to that channel's active compare value. It stays set until the matching match_clr bit is high at an edge. A set and a clear in the same cycle leave the flag set.
- R6: In waveform modes, a write to compare A (wr_cmp bit 0) fills only the shadow register, which becomes active at an edge where cnt_en is high and the count is at the wrap point. In other modes the write is active after one edge. Compare B and C writes are always active after one edge.
- R7: In waveform modes, pwm_out[i] is 1 while the count is less than channel i's active compare value, and 0 otherwise. In modes 0, 4 and 5 all pwm_out bits are 0.
- R8: In mode 6, pwm_out[0] stays 0.
- R9: With cap_rise high, a 0-to-1 step of evt_in is the capture edge. With cap_rise low, a 1-to-0 step is the capture edge. At that edge cap_val takes the count from before the edge and cap_flag sets. A capture beats a wr_cap in the same cycle, and a capture beats cap_clr in the same cycle.
- R10: Without a capture edge, wr_cap loads wr_data into cap_val.
- R11: If the wrap point is lowered below the current count, the counter keeps counting up through 0xFFFF, then rolls over to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count advance enable |
| mode | input | 3 | Wrap point and waveform mode select |
| cap_rise | input | 1 | 1 selects the rising capture edge, 0 the falling edge |
| evt_in | input | 1 | Synchronous event input |
| wr_cnt | input | 1 | Load the count from wr_data |
| wr_cmp | input | 3 | Per-channel compare write strobes (bit 0 is A) |
| wr_cap | input | 1 | Load cap_val from wr_data |
| wr_data | input | 16 | Shared write data |
| match_clr | input | 3 | Per-channel match flag clear |
| cap_clr | input | 1 | Capture flag clear |
| count | output | 16 | Current count |
| top_pulse | output | 1 | One-cycle pulse after a wrap |
| match_flag | output | 3 | Sticky compare match flags |
| cap_flag | output | 1 | Sticky capture flag |
| cap_val | output | 16 | Capture register |
| pwm_out | output | 3 | Per-channel PWM pins |

## Verification
Two kinds of event can land on the same clock edge. First, a compare match can meet a software clear of the same flag. Second, a capture edge can meet a software write (or clear) of the capture register. Both cases are forced on purpose: the bench parks the count on a compare value and raises the clear, and it flips evt_in in the same cycle as wr_cap and cap_clr. In both cases the bench expects the hardware event to win. A third case is a compare A write in the same cycle as the wrap in a waveform mode. This case comes up in the long random stretch, where the behavioural model must see the old shadow value become active while the new value is parked in the shadow register.

// File: rtl/wtmr_pkg.sv
// Shared mode encoding for the selectable-wrap timer.
// Assumes a 3-bit mode field; every code is defined.
package wtmr_pkg;

    typedef enum logic [2:0] {
        MD_FREE    = 3'd0,
        MD_PWM8    = 3'd1,
        MD_PWM9    = 3'd2,
        MD_PWM10   = 3'd3,
        MD_CLR_A   = 3'd4,
        MD_CLR_CAP = 3'd5,
        MD_PWM_A   = 3'd6,
        MD_PWM_CAP = 3'd7
    } wtmr_mode_e;

    // True for the modes that drive waveforms and shadow compare A
    function automatic logic mode_is_pwm(input wtmr_mode_e m);
        return (m != MD_FREE) && (m != MD_CLR_A) && (m != MD_CLR_CAP);
    endfunction

endpackage

// File: rtl/wtmr_top_sel.sv
// Picks the wrap point for the current mode and flags the waveform modes.
// Assumes CW >= 10 so the fixed narrow wrap points fit.
module wtmr_top_sel
    import wtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  wtmr_mode_e    mode,
    input  logic [CW-1:0] cmpa_act,
    input  logic [CW-1:0] cap_val,
    output logic [CW-1:0] top_val,
    output logic          pwm_mode
);
    localparam logic [CW-1:0] TOP_FULL = '1;
    localparam logic [CW-1:0] TOP_8    = CW'(8'hFF);
    localparam logic [CW-1:0] TOP_9    = CW'(9'h1FF);
    localparam logic [CW-1:0] TOP_10   = CW'(10'h3FF);

    // Wrap point multiplexer
    always_comb begin
        case (mode)
            MD_PWM8:               top_val = TOP_8;
            MD_PWM9:               top_val = TOP_9;
            MD_PWM10:              top_val = TOP_10;
            MD_CLR_A, MD_PWM_A:    top_val = cmpa_act;
            MD_CLR_CAP, MD_PWM_CAP: top_val = cap_val;
            default:               top_val = TOP_FULL;
        endcase
    end

    assign pwm_mode = mode_is_pwm(mode);
endmodule

// File: rtl/wtmr_chan.sv
// One compare channel: sticky match flag and fast-PWM level.
// Assumes the compare value is already the active (post-shadow) value.
module wtmr_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cmp_val,
    input  logic          clr,
    input  logic          pwm_en,
    output logic          flag_q,
    output logic          pwm
);
    logic hit;
    assign hit = cnt_en && (count == cmp_val);

    // Match flag: set wins over software clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign pwm = pwm_en && (count < cmp_val);
endmodule

// File: rtl/wtmr_capture.sv
// Edge-selected capture of the count with a sticky capture flag.
// Assumes evt_in is already synchronous to clk.
module wtmr_capture #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_in,
    input  logic          edge_rise,
    input  logic [CW-1:0] count,
    input  logic          wr,
    input  logic [CW-1:0] wr_data,
    input  logic          clr,
    output logic [CW-1:0] cap_q,
    output logic          flag_q
);
    logic prev_q, edge_hit;
    assign edge_hit = edge_rise ? (evt_in && !prev_q) : (!evt_in && prev_q);

    // Previous event level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= evt_in;
    end

    // Capture register: hardware capture beats software write
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (edge_hit) cap_q <= count;
        else if (wr)       cap_q <= wr_data;
    end

    // Capture flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (edge_hit) flag_q <= 1'b1;
        else if (clr)      flag_q <= 1'b0;
    end
endmodule

// File: rtl/wrap_timer.sv
// Up-counting timer with a mode-selected wrap point, NCH compare channels
// (channel 0 is shadowed in waveform modes) and an edge capture register.
// Assumes a synchronous event input and NCH >= 1.
module wrap_timer
    import wtmr_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_en,
    input  logic [2:0]     mode,
    input  logic           cap_rise,
    input  logic           evt_in,
    input  logic           wr_cnt,
    input  logic [NCH-1:0] wr_cmp,
    input  logic           wr_cap,
    input  logic [CW-1:0]  wr_data,
    input  logic [NCH-1:0] match_clr,
    input  logic           cap_clr,
    output logic [CW-1:0]  count,
    output logic           top_pulse,
    output logic [NCH-1:0] match_flag,
    output logic           cap_flag,
    output logic [CW-1:0]  cap_val,
    output logic [NCH-1:0] pwm_out
);
    wtmr_mode_e    mode_e;
    logic [CW-1:0] cnt_q, top_val, cmpa_buf_q, cmpa_act_q;
    logic          pwm_mode, at_top, wrap_now;

    assign mode_e   = wtmr_mode_e'(mode);
    assign at_top   = (cnt_q == top_val);
    assign wrap_now = cnt_en && at_top;

    wtmr_top_sel #(.CW(CW)) u_top_sel (
        .mode     (mode_e),
        .cmpa_act (cmpa_act_q),
        .cap_val  (cap_val),
        .top_val  (top_val),
        .pwm_mode (pwm_mode)
    );

    // Counter: load beats count, wrap to zero at the wrap point
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_cnt)   cnt_q <= wr_data;
        else if (wrap_now) cnt_q <= '0;
        else if (cnt_en)   cnt_q <= cnt_q + 1'b1;
    end

    // Wrap pulse, high the cycle after a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) top_pulse <= 1'b0;
        else        top_pulse <= wrap_now;
    end

    // Compare A shadow register, written on every A strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         cmpa_buf_q <= '0;
        else if (wr_cmp[0]) cmpa_buf_q <= wr_data;
    end

    // Compare A active register: direct in plain modes, at wrap in waveform modes
    always_ff @(posedge clk) begin
        if (!rst_n)                        cmpa_act_q <= '0;
        else if (wr_cmp[0] && !pwm_mode)   cmpa_act_q <= wr_data;
        else if (pwm_mode && wrap_now)     cmpa_act_q <= cmpa_buf_q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] cmp_now;
        logic          pwm_en;

        if (g == 0) begin : g_a
            assign cmp_now = cmpa_act_q;
            assign pwm_en  = pwm_mode && (mode_e != MD_PWM_A);
        end else begin : g_bc
            logic [CW-1:0] cmp_q;
            // Direct compare register for channels other than A
            always_ff @(posedge clk) begin
                if (!rst_n)         cmp_q <= '0;
                else if (wr_cmp[g]) cmp_q <= wr_data;
            end
            assign cmp_now = cmp_q;
            assign pwm_en  = pwm_mode;
        end

        wtmr_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (cnt_en),
            .count   (cnt_q),
            .cmp_val (cmp_now),
            .clr     (match_clr[g]),
            .pwm_en  (pwm_en),
            .flag_q  (match_flag[g]),
            .pwm     (pwm_out[g])
        );
    end

    wtmr_capture #(.CW(CW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .edge_rise (cap_rise),
        .count     (cnt_q),
        .wr        (wr_cap),
        .wr_data   (wr_data),
        .clr       (cap_clr),
        .cap_q     (cap_val),
        .flag_q    (cap_flag)
    );

    assign count = cnt_q;
endmodule

// File: rtl/wrap_timer_chk.sv
// Property checker for wrap_timer, attached by bind below.
// Assumes it observes the top ports plus the wrap point and compare A active value.
module wrap_timer_chk #(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cnt_en,
    input logic [2:0]     mode,
    input logic           wr_cnt,
    input logic [NCH-1:0] match_clr,
    input logic [CW-1:0]  count,
    input logic           top_pulse,
    input logic [NCH-1:0] match_flag,
    input logic           cap_flag,
    input logic [CW-1:0]  cap_val,
    input logic [NCH-1:0] pwm_out,
    input logic [CW-1:0]  top_val,
    input logic [CW-1:0]  cmpa_act,
    input logic           pwm_mode
);
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_cnt && count == top_val) |=> (count == '0));                // R4
    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (top_pulse && !$past(wr_cnt)) |-> (count == '0));                          // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_cnt) |=> $stable(count));                                  // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_cnt && count != top_val) |=> ((count - $past(count)) == CW'(1))); // R2
    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && !(cnt_en && count == top_val)) |=> $stable(cmpa_act));        // R6
    AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> (cap_val == $past(count)));                            // R9
    AST_A_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> !pwm_out[0]);                                           // R8
    AST_PLAIN_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode == 3'd4 || mode == 3'd5) |-> (pwm_out == '0));      // R7

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (match_flag[i] && !match_clr[i]) |=> match_flag[i]);                   // R5
    end
endmodule

bind wrap_timer wrap_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .mode       (mode),
    .wr_cnt     (wr_cnt),
    .match_clr  (match_clr),
    .count      (count),
    .top_pulse  (top_pulse),
    .match_flag (match_flag),
    .cap_flag   (cap_flag),
    .cap_val    (cap_val),
    .pwm_out    (pwm_out),
    .top_val    (top_val),
    .cmpa_act   (cmpa_act_q),
    .pwm_mode   (pwm_mode)
);

// File: tb/tb_wrap_timer.sv
`timescale 1ns/1ps
module tb_wrap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        cap_rise = 1'b1;
    logic        evt_in = 1'b0;
    logic        wr_cnt = 1'b0;
    logic [2:0]  wr_cmp = 3'b0;
    logic        wr_cap = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [2:0]  match_clr = 3'b0;
    logic        cap_clr = 1'b0;
    logic [15:0] count, cap_val;
    logic        top_pulse, cap_flag;
    logic [2:0]  match_flag, pwm_out;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    logic [15:0] m_cnt = 0, m_buf = 0, m_cap = 0;
    logic [15:0] m_cmp [3] = '{16'h0, 16'h0, 16'h0};
    logic [2:0]  m_fl = 0;
    logic        m_cf = 0, m_tp = 0, m_prev = 0;

    always #4 clk = ~clk;

    wrap_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
        .cap_rise(cap_rise), .evt_in(evt_in), .wr_cnt(wr_cnt), .wr_cmp(wr_cmp),
        .wr_cap(wr_cap), .wr_data(wr_data), .match_clr(match_clr), .cap_clr(cap_clr),
        .count(count), .top_pulse(top_pulse), .match_flag(match_flag),
        .cap_flag(cap_flag), .cap_val(cap_val), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_top(input logic [2:0] md);
        case (md)
            3'd1: return 16'h00FF;
            3'd2: return 16'h01FF;
            3'd3: return 16'h03FF;
            3'd4, 3'd6: return m_cmp[0];
            3'd5, 3'd7: return m_cap;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic ref_pwm_mode(input logic [2:0] md);
        return !(md == 3'd0 || md == 3'd4 || md == 3'd5);
    endfunction

    // one clock: advance the model at the edge, compare at the falling edge
    task automatic tick();
        logic [15:0] top, n_cnt, n_act, n_cap;
        logic        pm, at, hit;
        logic [2:0]  n_fl, exp_pwm;
        @(posedge clk);
        top = ref_top(mode);
        at  = (m_cnt == top);
        pm  = ref_pwm_mode(mode);
        for (int i = 0; i < 3; i++)
            n_fl[i] = (cnt_en && m_cnt == m_cmp[i]) ? 1'b1 : (match_clr[i] ? 1'b0 : m_fl[i]);
        n_act = m_cmp[0];
        if (wr_cmp[0] && !pm)      n_act = wr_data;
        else if (pm && cnt_en && at) n_act = m_buf;
        if (wr_cmp[0]) m_buf = wr_data;
        m_cmp[0] = n_act;
        for (int i = 1; i < 3; i++)
            if (wr_cmp[i]) m_cmp[i] = wr_data;
        hit = cap_rise ? (evt_in && !m_prev) : (!evt_in && m_prev);
        n_cap = hit ? m_cnt : (wr_cap ? wr_data : m_cap);
        m_cf  = hit ? 1'b1 : (cap_clr ? 1'b0 : m_cf);
        m_cap = n_cap;
        m_prev = evt_in;
        m_tp = cnt_en && at;
        if (wr_cnt)      n_cnt = wr_data;
        else if (cnt_en) n_cnt = at ? 16'h0 : m_cnt + 16'h1;
        else             n_cnt = m_cnt;
        m_cnt = n_cnt;
        m_fl  = n_fl;
        @(negedge clk);
        for (int i = 0; i < 3; i++)
            exp_pwm[i] = pm && (m_cnt < m_cmp[i]) && !(i == 0 && mode == 3'd6);
        chk("R2 count", count, m_cnt);
        chk("R4 top_pulse", top_pulse, m_tp);
        chk("R5 match_flag", match_flag, m_fl);
        chk("R9 cap_val", cap_val, m_cap);
        chk("R9 cap_flag", cap_flag, m_cf);
        chk("R7 pwm_out", pwm_out, exp_pwm);
    endtask

    // which: 0 count, 1..3 compare A..C, 4 capture
    task automatic wr(input int which, input logic [15:0] d);
        wr_data = d;
        if (which == 0)      wr_cnt = 1'b1;
        else if (which == 4) wr_cap = 1'b1;
        else                 wr_cmp[which-1] = 1'b1;
        tick();
        wr_cnt = 1'b0; wr_cap = 1'b0; wr_cmp = 3'b0;
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count", count, 0);
        chk("R1 cap_val", cap_val, 0);
        chk("R1 flags", {match_flag, cap_flag, top_pulse}, 0);
        chk("R1 pwm_out", pwm_out, 0);
        rst_n = 1'b1;

        // R2/R4: full range wrap
        wr(0, 16'hFFFD);
        chk("R2 load", count, 16'hFFFD);
        cnt_en = 1'b1;
        tick(); tick(); tick();
        chk("R4 wrap count", count, 0);
        chk("R4 pulse high", top_pulse, 1);
        tick();
        chk("R4 pulse low", top_pulse, 0);
        cnt_en = 1'b0;
        tick();
        chk("R2 hold", count, 1);

        // R6: shadowed compare A in 8-bit waveform mode
        wr(1, 16'd3);
        mode = 3'd1;
        wr(0, 16'd10);
        wr(1, 16'h40);
        chk("R6 shadow not yet active", pwm_out[0], 0);
        wr(0, 16'hFE);
        cnt_en = 1'b1;
        tick(); tick();
        chk("R3 8-bit wrap", count, 0);
        cnt_en = 1'b0;
        wr(0, 16'd10);
        chk("R6 shadow active after wrap", pwm_out[0], 1);

        // R3/R11: wrap at compare A, then lowered below count
        mode = 3'd4;
        wr(1, 16'd20);
        wr(0, 16'd15);
        cnt_en = 1'b1;
        repeat (5) tick();
        tick();
        chk("R3 wrap at compare A", count, 0);
        repeat (15) tick();
        wr(1, 16'd7);
        tick();
        chk("R11 runs past lowered wrap", count, 17);
        wr(0, 16'hFFFE);
        tick(); tick();
        chk("R11 rollover", count, 0);

        // R10/R3: wrap at capture register
        cnt_en = 1'b0;
        mode = 3'd5;
        wr(4, 16'd9);
        chk("R10 cap write", cap_val, 9);
        wr(0, 16'd8);
        cnt_en = 1'b1;
        tick(); tick();
        chk("R3 wrap at capture", count, 0);

        // R9: capture edges and collisions
        cnt_en = 1'b0;
        wr(0, 16'h123);
        cap_rise = 1'b1; evt_in = 1'b1;
        tick();
        chk("R9 rising capture", cap_val, 16'h123);
        chk("R9 flag set", cap_flag, 1);
        wr(0, 16'h200);
        evt_in = 1'b0; cap_rise = 1'b0; cap_clr = 1'b1;
        wr(4, 16'h555);
        cap_clr = 1'b0;
        chk("R9 capture beats write", cap_val, 16'h200);
        chk("R9 capture beats clear", cap_flag, 1);
        cap_clr = 1'b1; tick(); cap_clr = 1'b0;
        chk("R9 flag cleared", cap_flag, 0);

        // R5: match set against clear in the same cycle
        mode = 3'd0;
        wr(2, 16'h30);
        wr(0, 16'h30);
        cnt_en = 1'b1; match_clr = 3'b010;
        tick();
        match_clr = 3'b000;
        chk("R5 set beats clear", match_flag[1], 1);
        cnt_en = 1'b0; match_clr = 3'b010;
        tick();
        match_clr = 3'b000;
        chk("R5 cleared", match_flag[1], 0);

        // R8: compare A as wrap point in waveform mode
        mode = 3'd6;
        wr(2, 16'd3);
        cnt_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            tick();
            chk("R8 pin A quiet", pwm_out[0], 0);
        end

        // R3: 9 and 10 bit wrap points
        mode = 3'd2; cnt_en = 1'b0;
        wr(0, 16'h1FE);
        cnt_en = 1'b1; tick(); tick();
        chk("R3 9-bit wrap", count, 0);
        mode = 3'd3; cnt_en = 1'b0;
        wr(0, 16'h3FE);
        cnt_en = 1'b1; tick(); tick();
        chk("R3 10-bit wrap", count, 0);
        mode = 3'd7;
        wr(4, 16'h50);
        repeat (200) tick();

        // mixed random stimulus against the model
        for (int k = 0; k < 4000; k++) begin
            cnt_en    = ($urandom_range(9) != 0);
            evt_in    = $urandom_range(1);
            if ($urandom_range(99) == 0) cap_rise = $urandom_range(1);
            if ($urandom_range(199) == 0) mode = 3'($urandom_range(7));
            match_clr = 3'($urandom_range(7)) & 3'($urandom_range(7)) & 3'($urandom_range(7));
            cap_clr   = ($urandom_range(9) == 0);
            wr_data   = 16'($urandom_range(16'h3FF));
            wr_cnt    = ($urandom_range(299) == 0);
            wr_cap    = ($urandom_range(99) == 0);
            wr_cmp    = {($urandom_range(49) == 0), ($urandom_range(49) == 0), ($urandom_range(49) == 0)};
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule